// File: doc/BRIEF.md
# Shadow-ROM Boot Overlay

This block switches the memory map for a boot scheme that copies a boot ROM into RAM in place. After reset an overlay flag is set. While it is set, processor reads that fall in the ROM window return ROM data. Processor writes to the same addresses go to the RAM underneath. The boot code walks the ROM window, reading each word and writing it straight back, and so leaves a copy of the ROM in RAM.

The last address of the ROM window is the trigger. Once an access to it has finished, meaning the strobes have gone idle, the single overlay flop clears. From then on, every read and write in the window is served by RAM and the ROM is never selected again. Only a new reset brings the overlay back.

The ROM window is decoded by adding one gate to the existing RAM decode. The memories themselves sit outside the block, which drives only their selects.

Top module: `boot_shadow_map`

## Requirements
- R1: While `rst` is high, the `overlay` output goes high at the next clock edge and stays high after reset is released.
- R2: With `overlay` high, a read (`rd`=1, `wr`=0) at an address below ROM_WORDS gives `rom_sel`=1, `ram_sel`=0 and `ram_we`=0.
- R3: A write (`wr`=1, with or without `rd`) at an address below RAM_WORDS gives `ram_sel`=1, `ram_we`=1 and `rom_sel`=0 in either mode. A simultaneous read and write counts as a write.
- R4: A read at an address from ROM_WORDS up to RAM_WORDS-1 gives `ram_sel`=1, `ram_we`=0 and `rom_sel`=0.
- R5: An access at an address of RAM_WORDS or above selects nothing.
- R6: `rom_sel` and `ram_sel` are never high together, and with neither strobe high all three select outputs are low.
- R7: After an access (read or write) at address ROM_WORDS-1 while `overlay` is high, `overlay` stays high for as long as any strobe stays high. A write-back that follows the read with no gap therefore still reaches RAM with the overlay set. `overlay` falls at the first clock edge that samples both strobes low.
- R8: With `overlay` low, `rom_sel` is never asserted, and reads below ROM_WORDS select RAM.
- R9: With `overlay` low, further accesses, including accesses at address ROM_WORDS-1, leave it low. Only reset sets it again.
- R10: A read-then-write-back pass over addresses 0 to ROM_WORDS-1 leaves RAM holding the ROM image. Afterwards, reads in that range return the image from RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; sets the overlay |
| addr | input | AW | Processor address |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| rom_sel | output | 1 | Boot ROM select |
| ram_sel | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| overlay | output | 1 | High while the ROM overlays RAM for reads |

## Verification
The assertions take for granted that the strobes and the address are stable from one clock edge to the next, and that a strobe is only high for a real bus access. They also assume that the ROM window lies inside the RAM range, so a ROM hit is always a RAM hit too. The stimulus drives the address and strobes only on the falling clock edge, at most one access per cycle, and keeps ROM_WORDS below RAM_WORDS. The fall of the overlay is checked only through the idle cycle the bench leaves after the final write-back, and again after a held multi-cycle strobe.

// File: rtl/boot_shadow_pkg.sv
package boot_shadow_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_t;

    typedef struct packed {
        logic ram_hit;
        logic rom_hit;
        logic last_hit;
    } dec_t;

    typedef struct packed {
        logic rom_sel;
        logic ram_sel;
        logic ram_we;
    } sel_t;

    // a write strobe wins over a read strobe in the same cycle
    function automatic acc_t acc_of(input logic rd, input logic wr);
        if (wr)
            return ACC_WRITE;
        else if (rd)
            return ACC_READ;
        else
            return ACC_IDLE;
    endfunction

    function automatic logic is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/boot_shadow_decode.sv
module boot_shadow_decode
    import boot_shadow_pkg::*;
#(
    parameter int AW        = 8,
    parameter int ROM_WORDS = 16,
    parameter int RAM_WORDS = 192
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    localparam logic [AW:0]   RAM_LIM = (AW+1)'(RAM_WORDS);
    localparam logic [AW:0]   ROM_LIM = (AW+1)'(ROM_WORDS);
    localparam logic [AW-1:0] LAST_A  = AW'(ROM_WORDS - 1);
    localparam int            RB      = $clog2(ROM_WORDS);

    logic ram_hit;
    logic rom_win;

    // existing RAM decoder
    assign ram_hit = ({1'b0, addr} < RAM_LIM);

    generate
        if (is_pow2(ROM_WORDS) && (RB < AW)) begin : g_mask
            // power-of-two window: only the upper bits need to be zero
            assign rom_win = ~|addr[AW-1:RB];
        end else begin : g_cmp
            assign rom_win = ({1'b0, addr} < ROM_LIM);
        end
    endgenerate

    always_comb begin
        dec.ram_hit  = ram_hit;
        dec.rom_hit  = ram_hit & rom_win;   // the added gate
        dec.last_hit = (addr == LAST_A);
    end
endmodule

// File: rtl/boot_shadow_state.sv
module boot_shadow_state (
    input  logic clk,
    input  logic rst,
    input  logic access,
    input  logic last_hit,
    output logic ovl
);
    logic ovl_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovl_q  <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            if (ovl_q && access && last_hit)
                pend_q <= 1'b1;
            // clear on the trailing edge of the triggering access
            if (ovl_q && pend_q && !access) begin
                ovl_q  <= 1'b0;
                pend_q <= 1'b0;
            end
        end
    end

    assign ovl = ovl_q;

    // R1: reset arms the overlay
    p_reset_sets_r1: assert property (@(posedge clk) rst |=> ovl_q);

    // R9: once cleared, only reset brings it back
    p_no_rearm_r9: assert property (@(posedge clk) disable iff (rst)
        !ovl_q |=> !ovl_q);

    // R7: no clear while a strobe is still active
    p_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (ovl_q && access) |=> ovl_q);
endmodule

// File: rtl/boot_shadow_route.sv
module boot_shadow_route
    import boot_shadow_pkg::*;
(
    input  acc_t acc,
    input  dec_t dec,
    input  logic ovl,
    output sel_t sel
);
    always_comb begin
        sel = '0;
        unique case (acc)
            ACC_WRITE: begin
                sel.ram_sel = dec.ram_hit;
                sel.ram_we  = dec.ram_hit;
            end
            ACC_READ: begin
                if (ovl && dec.rom_hit)
                    sel.rom_sel = 1'b1;
                else
                    sel.ram_sel = dec.ram_hit;
            end
            default: sel = '0;
        endcase
    end
endmodule

// File: rtl/boot_shadow_map.sv
module boot_shadow_map
    import boot_shadow_pkg::*;
#(
    parameter int AW        = 8,
    parameter int ROM_WORDS = 16,
    parameter int RAM_WORDS = 192
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output logic          rom_sel,
    output logic          ram_sel,
    output logic          ram_we,
    output logic          overlay
);
    acc_t acc;
    dec_t dec;
    sel_t sel;
    logic ovl;

    assign acc = acc_of(rd, wr);

    boot_shadow_decode #(
        .AW(AW), .ROM_WORDS(ROM_WORDS), .RAM_WORDS(RAM_WORDS)
    ) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    boot_shadow_state u_state (
        .clk      (clk),
        .rst      (rst),
        .access   (acc != ACC_IDLE),
        .last_hit (dec.last_hit),
        .ovl      (ovl)
    );

    boot_shadow_route u_route (
        .acc (acc),
        .dec (dec),
        .ovl (ovl),
        .sel (sel)
    );

    assign rom_sel = sel.rom_sel;
    assign ram_sel = sel.ram_sel;
    assign ram_we  = sel.ram_we;
    assign overlay = ovl;

    // R6: no bus contention
    p_mutex_r6: assert property (@(posedge clk) disable iff (rst)
        !(rom_sel && ram_sel));

    // R8: ROM only while overlaid
    p_rom_needs_ovl_r8: assert property (@(posedge clk) disable iff (rst)
        rom_sel |-> (overlay && rd && !wr));

    // R3: write enable only on a write
    p_we_needs_wr_r3: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (wr && ram_sel));

    // R7: the overlay falls only after an idle cycle
    p_fall_after_idle_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(overlay) |-> $past(!rd && !wr));
endmodule

// File: tb/sim_boot_shadow_map.sv
module sim_boot_shadow_map;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int ROM_WORDS = 16;
    localparam int RAM_WORDS = 192;

    typedef struct packed {
        logic [7:0] a;
        logic rd, wr, er, em, ew;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{8'd0,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2
        '{8'd7,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2
        '{8'd14,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2
        '{8'd16,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4
        '{8'd191, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4
        '{8'd3,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R3
        '{8'd100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R3
        '{8'd2,   1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 both strobes
        '{8'd200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R5
        '{8'd192, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R5
        '{8'd5,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0}   // R6 idle
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          rd = 1'b0, wr = 1'b0;
    logic          rom_sel, ram_sel, ram_we, overlay;
    logic [7:0]    wdata = '0;
    logic [7:0]    ram [256];
    int            nchk = 0, nfail = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_shadow_map #(.AW(AW), .ROM_WORDS(ROM_WORDS), .RAM_WORDS(RAM_WORDS)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr),
        .rom_sel(rom_sel), .ram_sel(ram_sel), .ram_we(ram_we), .overlay(overlay)
    );

    // RAM model driven by the block's selects
    always @(posedge clk) if (ram_sel && ram_we) ram[addr] <= wdata;

    function automatic logic [7:0] rom_f(input int a);
        return 8'((a * 37 + 5) ^ 8'h5A);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // drive on the falling edge, sample 2 time units later
    task automatic drive(input int a, input logic r, input logic w);
        @(negedge clk);
        addr = AW'(a); rd = r; wr = w;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; rd = 1'b0; wr = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        #2;
    endtask

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        do_reset();
        chk("R1 overlay after reset", overlay, 1'b1);
        chk("R6 idle selects", {rom_sel, ram_sel, ram_we}, 3'b000);

        // vector table in overlay mode (last ROM address avoided)
        wdata = 8'hEE;
        for (int v = 0; v < NV; v++) begin
            drive(VT[v].a, VT[v].rd, VT[v].wr);
            chk($sformatf("R2/R3/R4/R5 vector %0d", v),
                {rom_sel, ram_sel, ram_we}, {VT[v].er, VT[v].em, VT[v].ew});
            drive(0, 1'b0, 1'b0);
            chk("R1 overlay kept", overlay, 1'b1);
        end

        // copy loop: read then write back, no gap
        for (int i = 0; i < ROM_WORDS; i++) begin
            drive(i, 1'b1, 1'b0);
            chk("R2 copy read from ROM", {rom_sel, ram_sel}, 2'b10);
            d = rom_sel ? rom_f(i) : ram[i];
            wdata = d;
            drive(i, 1'b0, 1'b1);
            chk("R3 write-back to RAM", {ram_sel, ram_we}, 2'b11);
            if (i == ROM_WORDS - 1)
                chk("R7 overlay held through write-back", overlay, 1'b1);
        end
        drive(0, 1'b0, 1'b0);
        chk("R7 overlay still high in idle cycle", overlay, 1'b1);
        drive(0, 1'b0, 1'b0);
        chk("R7 overlay low after idle edge", overlay, 1'b0);

        // verify image from RAM
        for (int i = 0; i < ROM_WORDS; i++) begin
            drive(i, 1'b1, 1'b0);
            chk("R8 read selects RAM", {rom_sel, ram_sel}, 2'b01);
            chk($sformatf("R10 image word %0d", i), ram[i], rom_f(i));
        end

        // repeated accesses to last address do nothing
        drive(ROM_WORDS - 1, 1'b1, 1'b0);
        drive(ROM_WORDS - 1, 1'b0, 1'b1);
        drive(0, 1'b0, 1'b0);
        drive(ROM_WORDS - 1, 1'b1, 1'b0);
        drive(0, 1'b0, 1'b0);
        drive(0, 1'b0, 1'b0);
        chk("R9 overlay stays low", overlay, 1'b0);
        drive(0, 1'b1, 1'b0);
        chk("R9 ROM not selected again", {rom_sel, ram_sel}, 2'b01);

        // reset re-arms
        do_reset();
        chk("R1 overlay after second reset", overlay, 1'b1);
        drive(4, 1'b1, 1'b0);
        chk("R9 reset re-arms ROM read", {rom_sel, ram_sel}, 2'b10);

        // held multi-cycle strobe at the last address
        drive(ROM_WORDS - 1, 1'b1, 1'b0);
        drive(ROM_WORDS - 1, 1'b1, 1'b0);
        chk("R7 held strobe keeps overlay", overlay, 1'b1);
        drive(ROM_WORDS - 1, 1'b1, 1'b0);
        chk("R7 held strobe keeps overlay 2", overlay, 1'b1);
        drive(0, 1'b0, 1'b0);
        chk("R7 high during idle", overlay, 1'b1);
        drive(0, 1'b0, 1'b0);
        chk("R7 low after held access", overlay, 1'b0);
        drive(ROM_WORDS - 1, 1'b1, 1'b0);
        chk("R8 last address reads RAM", {rom_sel, ram_sel}, 2'b01);
        drive(0, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule